// File: doc/BRIEF.md
# Context Register Shadow and Replay Unit

This unit sits on the register-write path that feeds a set of downstream rendering units. While in normal operation it forwards each upstream register write to the downstream bus unchanged and keeps a private copy of the value in a shadow store indexed by register address. Because every downstream register value also lives in the shadow, the downstream state can be saved and restored without ever reading those units back.

A context-switch token travels in the same upstream stream as ordinary writes, so every write ahead of it has already reached the downstream bus when it is taken. The token moves the unit out of `ST_PASS` into `ST_SWAP`. In that state the outgoing context streams out of a save port as address/data pairs in ascending address order. At the same time the incoming context streams in on a load port as address/data pairs in any order, and each pair overwrites its shadow entry. A load pair is held off until the save side has read the old value at that address, so nothing is lost while the two streams overlap. When the save stream has drained and the load stream has delivered its last pair, the unit enters `ST_REPLAY`. There it drives every shadow entry onto the downstream bus, address 0 upward, one write per cycle in which the downstream side is ready. It then returns to `ST_PASS`. Upstream traffic is blocked and `busy` is high from the token until the final replay write.

The states are `ST_PASS`, `ST_SWAP` and `ST_REPLAY`. There are three transitions: token taken (`ST_PASS` to `ST_SWAP`), save drained with load complete (`ST_SWAP` to `ST_REPLAY`), and last replay write taken (`ST_REPLAY` to `ST_PASS`).

Top module: `ctx_shadow_replay`

## Requirements
- R1: In `ST_PASS`, an upstream write (`up_valid`=1, `up_switch`=0) appears on the downstream bus in the same cycle with identical address and data, and `up_ready` equals `dn_ready`. A write taken this way replaces the shadow entry at its address.
- R2: In `ST_PASS`, a token (`up_valid`=1, `up_switch`=1) is taken at once (`up_ready`=1), is never forwarded downstream, and raises `busy` on the next cycle.
- R3: While `busy` is high, `up_ready` is 0, and the downstream bus carries only replay writes.
- R4: After a token, the save port emits exactly 2^ADDR_W pairs with addresses 0, 1, … 2^ADDR_W−1 in that order. Each data word is the shadow value at that address when the token was taken. `sv_last` is 1 only on the pair with the highest address, and a pair that is not taken holds steady.
- R5: A load pair at address A is accepted (`ld_ready`=1) only if the save side has already read address A, or is reading it in the same cycle. Pairs may come in any address order, and an accepted pair replaces shadow entry A.
- R6: The load pair flagged `ld_last`=1 ends the load stream. `ld_ready` is 0 in `ST_PASS`, in `ST_REPLAY`, and after that last pair.
- R7: Replay begins in the cycle after the save stream has drained and the last load pair has been taken. It drives one write per shadow address, 0 upward, carrying the restored value if one was loaded and the previously shadowed value if not. It advances only on cycles with `dn_ready`=1.
- R8: The last replay write being taken clears `busy` on the next cycle, and upstream writes pass through again.
- R9: After reset, `busy`, `sv_valid`, `ld_ready` and `dn_valid` are 0, and every shadow entry reads as zero.
- R10: The save and load streams run concurrently: load pairs are accepted while the save stream is still in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_valid | input | 1 | Upstream command valid |
| up_switch | input | 1 | Command is a context-switch token, not a write |
| up_addr | input | ADDR_W | Upstream register address |
| up_data | input | DATA_W | Upstream register data |
| up_ready | output | 1 | Upstream command taken |
| dn_valid | output | 1 | Downstream register write valid |
| dn_addr | output | ADDR_W | Downstream register address |
| dn_data | output | DATA_W | Downstream register data |
| dn_ready | input | 1 | Downstream side can take a write |
| sv_valid | output | 1 | Save pair valid |
| sv_addr | output | ADDR_W | Save pair address |
| sv_data | output | DATA_W | Save pair data |
| sv_last | output | 1 | Final save pair |
| sv_ready | input | 1 | Save consumer takes the pair |
| ld_valid | input | 1 | Load pair valid |
| ld_addr | input | ADDR_W | Load pair address |
| ld_data | input | DATA_W | Load pair data |
| ld_last | input | 1 | Final load pair |
| ld_ready | output | 1 | Load pair taken |
| busy | output | 1 | Context switch in progress |

## Verification
A corrupt shadow entry does not show up while the unit passes writes through. It appears only at the next context switch: first in the save pair for that address, and again in the replay write for that address at most 2^ADDR_W replay cycles later. A wrong save index or a misplaced load gate shows within one handshake, as an out-of-order save address, a load pair accepted before its address was saved, or a save word carrying the newly loaded value instead of the old one. The bench keeps its own behavioural model of the shadow and the two stream positions and compares every output on every cycle, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/ctxsh_pkg.sv
package ctxsh_pkg;
    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,
        ST_SWAP   = 2'd1,
        ST_REPLAY = 2'd2
    } ctx_state_e;
endpackage

// File: rtl/ctxsh_store.sv
module ctxsh_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/ctxsh_save.sv
module ctxsh_save #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              sv_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fire,
    output logic [ADDR_W:0]   idx,
    output logic              done,
    output logic              sv_valid,
    output logic [ADDR_W-1:0] sv_addr,
    output logic [DATA_W-1:0] sv_data,
    output logic              sv_last
);
    localparam int          DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] END_IDX = ADDR_W'(0) | (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    assign rd_addr = idx[ADDR_W-1:0];
    assign fire    = run && !idx[ADDR_W] && (!sv_valid || sv_ready);
    assign done    = (idx == END_IDX) && !sv_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (start) begin
            idx <= '0;
        end else if (fire) begin
            idx <= idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv_valid <= 1'b0;
            sv_addr  <= '0;
            sv_data  <= '0;
            sv_last  <= 1'b0;
        end else if (fire) begin
            sv_valid <= 1'b1;
            sv_addr  <= rd_addr;
            sv_data  <= rd_data;
            sv_last  <= (rd_addr == TOP_ADDR);
        end else if (sv_ready) begin
            sv_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ctxsh_restore.sv
module ctxsh_restore #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_last,
    input  logic [ADDR_W:0]   save_idx,
    input  logic              save_fire,
    output logic              ld_ready,
    output logic              take,
    output logic              done
);
    logic [ADDR_W:0] addr_ext;
    logic            already_saved;
    logic            saving_now;

    assign addr_ext      = {1'b0, ld_addr};
    assign already_saved = addr_ext < save_idx;
    assign saving_now    = (addr_ext == save_idx) && save_fire;
    assign ld_ready      = run && !done && (already_saved || saving_now);
    assign take          = ld_valid && ld_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (start) begin
            done <= 1'b0;
        end else if (take && ld_last) begin
            done <= 1'b1;
        end
    end
endmodule

// File: rtl/ctx_shadow_replay.sv
module ctx_shadow_replay
    import ctxsh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic              up_switch,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ready,
    output logic              dn_valid,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_ready,
    output logic              sv_valid,
    output logic [ADDR_W-1:0] sv_addr,
    output logic [DATA_W-1:0] sv_data,
    output logic              sv_last,
    input  logic              sv_ready,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_last,
    output logic              ld_ready,
    output logic              busy
);
    localparam int                DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    ctx_state_e        state_q, state_d;
    logic [ADDR_W-1:0] rp_idx;
    logic              tok_take, pass_wr, in_swap;
    logic              sv_fire, sv_done, ld_take, ld_done;
    logic [ADDR_W:0]   sv_idx;
    logic [ADDR_W-1:0] sv_rd_addr;
    logic [DATA_W-1:0] sv_rd_data, rp_rd_data;
    logic              st_wr_en;
    logic [ADDR_W-1:0] st_wr_addr;
    logic [DATA_W-1:0] st_wr_data;

    assign in_swap  = (state_q == ST_SWAP);
    assign tok_take = (state_q == ST_PASS) && up_valid && up_switch;
    assign pass_wr  = (state_q == ST_PASS) && up_valid && !up_switch && dn_ready;

    assign st_wr_en   = pass_wr || ld_take;
    assign st_wr_addr = in_swap ? ld_addr : up_addr;
    assign st_wr_data = in_swap ? ld_data : up_data;

    ctxsh_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_wr_en),
        .wr_addr   (st_wr_addr),
        .wr_data   (st_wr_data),
        .rd_a_addr (sv_rd_addr),
        .rd_a_data (sv_rd_data),
        .rd_b_addr (rp_idx),
        .rd_b_data (rp_rd_data)
    );

    ctxsh_save #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_save (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tok_take),
        .run      (in_swap),
        .sv_ready (sv_ready),
        .rd_addr  (sv_rd_addr),
        .rd_data  (sv_rd_data),
        .fire     (sv_fire),
        .idx      (sv_idx),
        .done     (sv_done),
        .sv_valid (sv_valid),
        .sv_addr  (sv_addr),
        .sv_data  (sv_data),
        .sv_last  (sv_last)
    );

    ctxsh_restore #(.ADDR_W(ADDR_W)) u_restore (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tok_take),
        .run       (in_swap),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_last   (ld_last),
        .save_idx  (sv_idx),
        .save_fire (sv_fire),
        .ld_ready  (ld_ready),
        .take      (ld_take),
        .done      (ld_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
        end else begin
            state_q <= state_d;
        end
    end

    // replay position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_idx <= '0;
        end else if (tok_take) begin
            rp_idx <= '0;
        end else if ((state_q == ST_REPLAY) && dn_ready) begin
            rp_idx <= rp_idx + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS:   if (tok_take) state_d = ST_SWAP;
            ST_SWAP:   if (sv_done && ld_done) state_d = ST_REPLAY;
            ST_REPLAY: if (dn_ready && (rp_idx == TOP_ADDR)) state_d = ST_PASS;
            default:   state_d = ST_PASS;
        endcase
    end

    // outputs
    always_comb begin
        up_ready = 1'b0;
        dn_valid = 1'b0;
        dn_addr  = up_addr;
        dn_data  = up_data;
        busy     = 1'b1;
        unique case (state_q)
            ST_PASS: begin
                busy     = 1'b0;
                up_ready = up_switch ? 1'b1 : dn_ready;
                dn_valid = up_valid && !up_switch;
            end
            ST_SWAP: begin
            end
            ST_REPLAY: begin
                dn_valid = 1'b1;
                dn_addr  = rp_idx;
                dn_data  = rp_rd_data;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/ctxsh_chk.sv
module ctxsh_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_switch,
    input logic [ADDR_W-1:0] up_addr,
    input logic [DATA_W-1:0] up_data,
    input logic              up_ready,
    input logic              dn_valid,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [DATA_W-1:0] dn_data,
    input logic              dn_ready,
    input logic              sv_valid,
    input logic [ADDR_W-1:0] sv_addr,
    input logic [DATA_W-1:0] sv_data,
    input logic              sv_last,
    input logic              sv_ready,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [DATA_W-1:0] ld_data,
    input logic              ld_last,
    input logic              ld_ready,
    input logic              busy
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'((1 << ADDR_W) - 1);

    // R1
    pass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && up_valid && !up_switch) |-> (dn_valid && dn_addr == up_addr && dn_data == up_data));

    // R2
    token_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_switch && up_ready) |=> busy);

    // R3
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !up_ready);

    // R4
    save_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sv_valid && sv_last) |-> (sv_addr == TOP_ADDR));

    // R4
    save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sv_valid && !sv_ready) |=> (sv_valid && $stable(sv_addr) && $stable(sv_data) && $stable(sv_last)));

    // R6
    load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> busy);

    // R8
    replay_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(dn_valid && dn_ready && dn_addr == TOP_ADDR));
endmodule

bind ctx_shadow_replay ctxsh_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_ctx_shadow_replay.sv
module test_ctx_shadow_replay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 0, up_switch = 0;
    logic [7:0]  up_addr = 0;
    logic [31:0] up_data = 0;
    logic        up_ready;
    logic        dn_valid;
    logic [7:0]  dn_addr;
    logic [31:0] dn_data;
    logic        dn_ready = 1;
    logic        sv_valid, sv_last;
    logic [7:0]  sv_addr;
    logic [31:0] sv_data;
    logic        sv_ready = 1;
    logic        ld_valid = 0, ld_last = 0;
    logic [7:0]  ld_addr = 0;
    logic [31:0] ld_data = 0;
    logic        ld_ready;
    logic        busy;

    int n_chk = 0, n_fail = 0, cyc = 0, overlap = 0;
    bit rnd_en = 0;

    always #5 clk = ~clk;

    ctx_shadow_replay i_ctx_shadow_replay (.*);

    // behavioural model
    int          mst, ms, mr;
    bit          mdone, msv_v, msv_l;
    int          msv_a;
    logic [31:0] msv_d;
    logic [31:0] mshadow [256];

    bit          e_up_ready, e_dn_valid, e_ld_ready, e_fire;
    logic [7:0]  e_dn_addr;
    logic [31:0] e_dn_data;

    always_comb begin
        e_fire     = (mst == 1) && (ms < 256) && (!msv_v || sv_ready);
        e_up_ready = (mst == 0) && (up_switch || dn_ready);
        e_dn_valid = (mst == 0) ? (up_valid && !up_switch) : (mst == 2);
        e_dn_addr  = (mst == 2) ? 8'(mr) : up_addr;
        e_dn_data  = (mst == 2) ? mshadow[mr] : up_data;
        e_ld_ready = (mst == 1) && !mdone &&
                     ((int'(ld_addr) < ms) || ((int'(ld_addr) == ms) && e_fire));
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit f, lt, fin;
        cyc++;
        if (!rst_n) begin
            mst = 0; ms = 0; mr = 0; mdone = 0; msv_v = 0; msv_l = 0; msv_a = 0; msv_d = 0;
            for (int i = 0; i < 256; i++) mshadow[i] = 0;
        end else begin
            f   = e_fire;
            lt  = ld_valid && e_ld_ready;
            fin = (ms == 256) && !msv_v && mdone;
            case (mst)
                0: if (up_valid && e_up_ready) begin
                       if (up_switch) begin mst = 1; ms = 0; mdone = 0; mr = 0; end
                       else mshadow[up_addr] = up_data;
                   end
                1: begin
                       if (lt && ms < 256) overlap++;
                       if (f) begin
                           msv_v = 1; msv_a = ms; msv_d = mshadow[ms]; msv_l = (ms == 255); ms++;
                       end else if (sv_ready) msv_v = 0;
                       if (lt) begin
                           mshadow[ld_addr] = ld_data;
                           if (ld_last) mdone = 1;
                       end
                       if (fin) mst = 2;
                   end
                default: if (dn_ready) begin
                       if (mr == 255) mst = 0;
                       mr = (mr + 1) % 256;
                   end
            endcase
            if (mst != 1 && !f && sv_ready) msv_v = 0;
        end
    end

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(up_ready == e_up_ready, (mst == 0) ? "R1" : "R3", "up_ready", 32'(up_ready), 32'(e_up_ready));
            chk(busy == (mst != 0), (mst == 2) ? "R8" : "R2", "busy", 32'(busy), 32'(mst != 0));
            chk(dn_valid == e_dn_valid, (mst == 0) ? "R1" : "R3", "dn_valid", 32'(dn_valid), 32'(e_dn_valid));
            if (e_dn_valid) begin
                chk(dn_addr == e_dn_addr, (mst == 2) ? "R7" : "R1", "dn_addr", 32'(dn_addr), 32'(e_dn_addr));
                chk(dn_data == e_dn_data, (mst == 2) ? "R7" : "R1", "dn_data", dn_data, e_dn_data);
            end
            chk(sv_valid == msv_v, "R4", "sv_valid", 32'(sv_valid), 32'(msv_v));
            if (msv_v) begin
                chk(sv_addr == 8'(msv_a), "R4", "sv_addr", 32'(sv_addr), 32'(msv_a));
                chk(sv_data == msv_d, "R4", "sv_data", sv_data, msv_d);
                chk(sv_last == msv_l, "R4", "sv_last", 32'(sv_last), 32'(msv_l));
            end
            chk(ld_ready == e_ld_ready, (mst == 1 && !mdone) ? "R5" : "R6", "ld_ready", 32'(ld_ready), 32'(e_ld_ready));
        end
    end

    always @(posedge clk) if (rnd_en) begin
        #1;
        sv_ready = ($urandom % 4) != 0;
        dn_ready = ($urandom % 3) != 0;
    end

    task automatic up_send(input logic [7:0] a, input logic [31:0] d, input logic sw);
        @(posedge clk); #2;
        up_valid = 1; up_addr = a; up_data = d; up_switch = sw;
        do @(negedge clk); while (!up_ready);
        @(posedge clk); #2;
        up_valid = 0; up_switch = 0;
    endtask

    task automatic ld_send(input logic [7:0] a, input logic [31:0] d, input logic last);
        @(posedge clk); #2;
        ld_valid = 1; ld_addr = a; ld_data = d; ld_last = last;
        do @(negedge clk); while (!ld_ready);
        @(posedge clk); #2;
        ld_valid = 0; ld_last = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(!busy && !sv_valid && !ld_ready && !dn_valid, "R9", "reset outputs",
            {28'd0, busy, sv_valid, ld_ready, dn_valid}, 32'd0);

        // R1 pass-through with varying downstream readiness
        rnd_en = 1;
        up_send(8'h00, 32'h1111_0000, 0);
        up_send(8'hFF, 32'hFFFF_00FF, 0);
        up_send(8'h03, 32'h0000_0333, 0);
        up_send(8'h0A, 32'hAAAA_000A, 0);
        up_send(8'h03, 32'h0303_0303, 0);
        for (int i = 16; i < 40; i++) up_send(8'(i), 32'(i * 7919), 0);

        // Scenario A: sparse out-of-order load, write pressure during busy (R3, R5, R8)
        fork
            begin
                up_send(8'h00, 32'h0, 1);
                up_send(8'h42, 32'h0000_BEEF, 0);
            end
            begin
                do @(negedge clk); while (!busy);
                ld_send(8'hFF, 32'hC0DE_00FF, 0);
                ld_send(8'h03, 32'hC0DE_0003, 0);
                ld_send(8'h0A, 32'hC0DE_000A, 0);
                ld_send(8'h03, 32'hC0DE_3333, 1);
            end
        join
        wait_idle();

        // Scenario B: full ascending load in lockstep with random save back-pressure (R10)
        fork
            up_send(8'h00, 32'h0, 1);
            begin
                do @(negedge clk); while (!busy);
                for (int k = 0; k < 256; k++) ld_send(8'(k), 32'h5A00_0000 | 32'(k), k == 255);
            end
        join
        wait_idle();
        chk(overlap > 0, "R10", "overlapped load pairs", 32'(overlap), 32'd1);

        // Scenario C: single load pair, save stalled at first
        rnd_en = 0; sv_ready = 0; dn_ready = 1;
        fork
            up_send(8'h00, 32'h0, 1);
            begin
                do @(negedge clk); while (!busy);
                fork
                    ld_send(8'h00, 32'h7777_7777, 1);
                    begin repeat (6) @(posedge clk); #2 sv_ready = 1; rnd_en = 1; end
                join
            end
        join
        wait_idle();

        up_send(8'h10, 32'h0BAD_F00D, 0);
        up_send(8'h11, 32'h1234_5678, 0);
        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule